// File: doc/BRIEF.md
# DRAM Cycle Strobe Sequencer

This block produces the row strobe, column strobe and write strobe waveform for a single DRAM access or a single refresh cycle. A small 8-bit timing register sets the shape of the waveform. It holds three fields: the length of the row precharge phase, the number of wait states placed between the row and column strobes, and an enable for one idle state after the cycle. The idle state is added only when the following bus cycle goes to normal (non-DRAM) space.

A bus controller offers a request together with write and refresh qualifiers. The block accepts the request when it signals ready, runs the whole sequence, and pulses a done flag in the final state. At the moment of acceptance, the timing fields are copied into the sequencer. Register writes are honoured only while the sequencer is idle, so a new setting applies from the next accepted request onward. The block models timing only. It does not handle address multiplexing, data or refresh scheduling.

Top module: `dram_cyc_seq`

## Requirements
- R1: After reset the register reads 0x00, ras_n, cas_n and we_n are high, req_ready is high and cyc_done is low.
- R2: While req_ready is high, a write with cfg_wr_en stores all 8 bits of cfg_wdata, including the reserved bits 6, 3 and 2. The stored value appears on cfg_rdata from the next cycle.
- R3: Bits 5:4 hold value p. Every accepted request, access or refresh, starts with p+1 states in which ras_n and cas_n are both high.
- R4: Bits 1:0 hold value w. In an access, precharge is followed by one state with only ras_n low, then w further states with ras_n low and cas_n high.
- R5: An access then has one state with ras_n and cas_n low, in which we_n is low exactly when req_write was high at acceptance. Next comes one state with all strobes high and cyc_done high.
- R6: In a refresh (req_refresh high at acceptance), precharge is followed by one state with cas_n low and ras_n high, then one state with both low, then the done state. we_n stays high for the whole cycle.
- R7: If bit 7 is 1 and next_normal is high during the done state, one extra state follows with all strobes high and req_ready low. Otherwise req_ready returns high in the state right after done.
- R8: req_ready is high only in the idle state. A req_valid seen while req_ready is low starts nothing.
- R9: A register write while req_ready is low is ignored.
- R10: A request uses the register value held when it is accepted. A write in that same cycle is stored and affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Timing register write strobe |
| cfg_wdata | input | 8 | Timing register write data |
| cfg_rdata | output | 8 | Timing register contents |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | Request is a write access |
| req_refresh | input | 1 | Request is a refresh cycle |
| next_normal | input | 1 | Next bus cycle targets normal space |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| cyc_done | output | 1 | High in the final state of a cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
A register write and the acceptance of a request can happen in the same idle cycle. The bench provokes this by driving cfg_wr_en and req_valid on one edge with differing timing values. It then judges the strobe waveform against the older register value and checks that the readback holds the new one. A second collision is also covered: a write issued in the middle of a running cycle. The bench verifies that the readback after the cycle is unchanged.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int REG_W    = 8;
    localparam int FLD_W    = 2;
    localparam int IDLE_BIT = 7;
    localparam int PRE_LSB  = 4;
    localparam int RCD_LSB  = 0;

    typedef struct packed {
        logic             idle_en;
        logic [FLD_W-1:0] pre;
        logic [FLD_W-1:0] rcd;
    } timing_t;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PRE   = 4'd1,
        ST_RAS   = 4'd2,
        ST_RCD   = 4'd3,
        ST_CAS   = 4'd4,
        ST_RF_C  = 4'd5,
        ST_RF_R  = 4'd6,
        ST_DONE  = 4'd7,
        ST_GAP   = 4'd8
    } seq_state_e;

    function automatic timing_t unpack_timing(input logic [REG_W-1:0] r);
        timing_t t;
        t.idle_en = r[IDLE_BIT];
        t.pre     = r[PRE_LSB +: FLD_W];
        t.rcd     = r[RCD_LSB +: FLD_W];
        return t;
    endfunction

endpackage

// File: rtl/dram_seq_cfg.sv
module dram_seq_cfg
    import dram_seq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_allow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output timing_t      timing
);

    logic [W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en && wr_allow) begin
            reg_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata  = reg_q;
    assign timing = unpack_timing(reg_q);

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    is_write,
    input  logic    is_refresh,
    input  logic    next_normal,
    input  timing_t timing,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n,
    output logic    done,
    output logic    ready
);

    typedef struct packed {
        seq_state_e       st;
        logic [FLD_W-1:0] cnt;
        timing_t          tm;
        logic             wr;
        logic             rf;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             done;
        logic             ready;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st: ST_IDLE, cnt: '0, tm: '0, wr: 1'b0, rf: 1'b0,
        ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, done: 1'b0, ready: 1'b1
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.tm  = timing;
                    s_d.wr  = is_write;
                    s_d.rf  = is_refresh;
                    s_d.cnt = timing.pre;
                    s_d.st  = ST_PRE;
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.st = s_q.rf ? ST_RF_C : ST_RAS;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RAS: begin
                if (s_q.tm.rcd == '0) begin
                    s_d.st = ST_CAS;
                end else begin
                    s_d.cnt = s_q.tm.rcd - 1'b1;
                    s_d.st  = ST_RCD;
                end
            end
            ST_RCD: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_CAS;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CAS:  s_d.st = ST_DONE;
            ST_RF_C: s_d.st = ST_RF_R;
            ST_RF_R: s_d.st = ST_DONE;
            ST_DONE: begin
                s_d.st = (s_q.tm.idle_en && next_normal) ? ST_GAP : ST_IDLE;
            end
            ST_GAP:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase

        // registered strobes follow the next state
        s_d.ras_n = !(s_d.st inside {ST_RAS, ST_RCD, ST_CAS, ST_RF_R});
        s_d.cas_n = !(s_d.st inside {ST_CAS, ST_RF_C, ST_RF_R});
        s_d.we_n  = !((s_d.st == ST_CAS) && s_d.wr);
        s_d.done  = (s_d.st == ST_DONE);
        s_d.ready = (s_d.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n = s_q.ras_n;
    assign cas_n = s_q.cas_n;
    assign we_n  = s_q.we_n;
    assign done  = s_q.done;
    assign ready = s_q.ready;

endmodule

// File: rtl/dram_cyc_seq.sv
module dram_cyc_seq
    import dram_seq_pkg::*;
#(
    parameter int CFG_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_refresh,
    input  logic             next_normal,
    output logic             req_ready,
    output logic             cyc_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n
);

    timing_t tm;
    logic    idle_w;

    dram_seq_cfg #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_allow (idle_w),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .timing   (tm)
    );

    dram_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_valid),
        .is_write    (req_write),
        .is_refresh  (req_refresh),
        .next_normal (next_normal),
        .timing      (tm),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .done        (cyc_done),
        .ready       (idle_w)
    );

    assign req_ready = idle_w;

endmodule

// File: rtl/dram_cyc_seq_chk.sv
module dram_cyc_seq_chk #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cyc_done,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n
);

    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && req_ready) |=> (cfg_rdata == $past(cfg_wdata)));

    assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(cfg_rdata));

    assert_accept_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ras_n && cas_n && !req_ready));

    assert_we_in_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ras_n && !cas_n));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (ras_n && cas_n && we_n && !req_ready));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |=> (!cas_n && !ras_n && we_n));

endmodule

bind dram_cyc_seq dram_cyc_seq_chk #(.CFG_W(CFG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cyc_done  (cyc_done),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n)
);

// File: tb/dram_cyc_seq_tb.sv
module dram_cyc_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_refresh = 1'b0;
    logic       next_normal = 1'b0;
    logic       req_ready, cyc_done, ras_n, cas_n, we_n;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl_reg = '0;

    always #10 clk = ~clk;

    dram_cyc_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_refresh(req_refresh),
        .next_normal(next_normal), .req_ready(req_ready), .cyc_done(cyc_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // expected {ras_n, cas_n, we_n, cyc_done, req_ready} k cycles after acceptance
    function automatic logic [4:0] exp_vec(input int k, input int n, input int m,
                                           input bit wr, input bit rf, input bit gap);
        int dk;
        dk = rf ? n + 2 : n + m + 2;
        if (k < n) return 5'b11100;
        if (rf) begin
            if (k == n)     return 5'b10100;
            if (k == n + 1) return 5'b00100;
        end else begin
            if (k <= n + m)     return 5'b01100;
            if (k == n + m + 1) return {2'b00, !wr, 2'b00};
        end
        if (k == dk) return 5'b11110;
        if (k == dk + 1 && gap) return 5'b11100;
        return 5'b11101;
    endfunction

    function automatic string tag_of(input int k, input int n, input int m,
                                     input bit rf, input bit gap);
        int dk;
        dk = rf ? n + 2 : n + m + 2;
        if (k < n) return "R3";
        if (k < dk) return rf ? "R6" : (k == n + m + 1 ? "R5" : "R4");
        if (k == dk) return "R5";
        if (k == dk + 1 && gap) return "R7";
        return "R7/R8";
    endfunction

    task automatic cfg_write(input logic [7:0] data);
        cfg_wr_en = 1'b1;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        mdl_reg = data;
        chk("R2 readback", cfg_rdata, data);
    endtask

    task automatic run_txn(input bit wr, input bit rf, input bit nn, input bit hold,
                           input bit wr_same, input logic [7:0] wd_same);
        logic [7:0] snap;
        int n, m, len;
        bit gap;
        req_valid = 1'b1;
        req_write = wr;
        req_refresh = rf;
        next_normal = nn;
        snap = mdl_reg;
        if (wr_same) begin
            cfg_wr_en = 1'b1;
            cfg_wdata = wd_same;
            mdl_reg = wd_same;     // R10: stored, but this request uses snap
        end
        n = int'(snap[5:4]) + 1;
        m = int'(snap[1:0]);
        gap = snap[7] && nn;
        len = (rf ? n + 2 : n + m + 2) + 1 + (gap ? 1 : 0);
        for (int k = 0; k <= len; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cfg_wr_en = 1'b0;
                if (!hold) req_valid = 1'b0;
            end
            chk(tag_of(k, n, m, rf, gap),
                {27'd0, ras_n, cas_n, we_n, cyc_done, req_ready},
                {27'd0, exp_vec(k, n, m, wr, rf, gap)});
            if (k == 1) begin
                cfg_wr_en = 1'b1;          // R9: write while busy
                cfg_wdata = 8'($urandom);
            end
            if (k == 2) cfg_wr_en = 1'b0;
            if (hold && k == len - 1) req_valid = 1'b0;
        end
        chk("R9/R10 reg after cycle", cfg_rdata, mdl_reg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1d2c3b4a);
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {27'd0, ras_n, cas_n, we_n, cyc_done, req_ready}, 32'b11101);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset reg", cfg_rdata, 8'h00);
        chk("R1 idle outputs", {27'd0, ras_n, cas_n, we_n, cyc_done, req_ready}, 32'b11101);

        // directed corners
        run_txn(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);   // shortest read, reg 0
        cfg_write(8'h4C);                               // reserved bits only
        chk("R2 reserved kept", cfg_rdata, 8'h4C);
        run_txn(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);   // reserved bits no timing effect
        cfg_write(8'hFF);
        run_txn(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);   // longest write, gap, held req
        run_txn(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);   // refresh, long precharge
        run_txn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);   // idle_en but next not normal
        cfg_write(8'h21);
        run_txn(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h93);   // same-cycle write, old timing
        run_txn(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);   // new timing now in effect
        cfg_write(8'h00);
        run_txn(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);   // refresh, no gap

        // constrained random
        for (int i = 0; i < 80; i++) begin
            if (($urandom % 3) == 0) cfg_write(8'($urandom));
            run_txn(1'($urandom), (($urandom % 4) == 0), 1'($urandom),
                    1'($urandom), (($urandom % 5) == 0), 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule